// File: doc/BRIEF.md
# Planar Video Memory Access Datapath

This block connects a byte-wide processor port to four 8-bit memory planes that share one address. Every processor read fetches the byte at that address from all four planes into a hidden 32-bit latch. The byte returned depends on the read mode: either one selected plane, or a colour-match byte computed across all four planes.

A processor write produces one byte per plane. Each byte is built from the processor data, a per-plane set/reset colour and the latched bytes. The path runs through a right-rotator, a logic unit and a per-bit mask. Only the planes enabled in a plane-write mask are written. Because masked-off bit positions take their value from the latch, a read followed by a write of any value can repaint pixels with colours already stored elsewhere in memory.

Nine control registers set the behaviour. They are reached through an index/data pair. The plane storage is part of the block, so all effects can be seen by reading back through the processor port.

Top module: `planar_vid_datapath`

## Requirements
- R1: After reset, cpu_rvalid and cpu_rdata are 0. The control registers reset to: bit mask 0xFF, plane-write mask 0xF, colour-care mask 0xF, all others 0.
- R2: A read (cpu_req=1, cpu_we=0) loads the latch from all four planes at cpu_addr. In the following cycle, cpu_rvalid=1 and cpu_rdata holds the result. In read mode 0, the result is the byte of the plane selected by bits 1:0 of register 4.
- R3: Register 5 holds the modes. Bits 1:0 select the write mode and bit 3 selects the read mode.
- R4: Register 3 controls the data path. Bits 2:0 give a right-rotate count applied to cpu_wdata. Bits 4:3 choose the logic operation against the plane's latched byte: 0 pass, 1 AND, 2 OR, 3 XOR.
- R5: In write mode 0, for each plane p whose bit is set in the enable register (index 1), bit p of the set/reset register (index 0) is replicated to 8 bits and replaces the rotated data.
- R6: In write modes 0 and 2, each bit position takes the logic-unit output where the bit mask (register 7) is 1. Where the mask is 0, the bit position takes the latched bit.
- R7: A write changes only the planes whose bit is set in the plane-write mask (register 8, bits 3:0). The other planes keep their contents.
- R8: Write mode 1 stores the latched byte of each plane unchanged.
- R9: In write mode 2, plane p receives cpu_wdata bit p replicated to 8 bits, before the logic unit and the mask.
- R10: Write mode 3 works as follows. The set/reset bit p, replicated, feeds the logic unit for plane p. The effective mask is the rotated cpu_wdata ANDed with the bit mask.
- R11: In read mode 1, bit b of the result is 1 when every plane p with colour-care bit p set (register 6) has bit b equal to bit p of the colour-compare register (register 2).
- R12: A register access with reg_port=0 loads the index. An access with reg_port=1 writes reg_wdata into the register the index selects. Indices are 0 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access strobe |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Byte address within each plane |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read result, registered |
| cpu_rvalid | output | 1 | Read result valid |
| reg_wr | input | 1 | Register port write strobe |
| reg_port | input | 1 | 0 selects index, 1 selects data |
| reg_wdata | input | 8 | Register port write value |

## Verification
The assertions assume the following about the inputs:
- cpu_req, cpu_we and cpu_addr are settled values, driven away from the clock edge.
- A register write and a processor access never fall in the same cycle.
- The latch is only read back through the latch-copy and mask paths after a read has loaded it.

The stimulus keeps within these limits:
- Every access and every register write occupies exactly one clock cycle and then returns to idle.
- Register changes always finish before the access that depends on them.
- Each write that relies on latched data is preceded by a read of a known address.

// File: rtl/planar_vid_pkg.sv
package planar_vid_pkg;

    localparam int NPLANES = 4;
    localparam int BYTE_W  = 8;

    typedef enum logic [3:0] {
        IX_SETRST  = 4'd0,
        IX_SR_EN   = 4'd1,
        IX_CMP     = 4'd2,
        IX_ROTOP   = 4'd3,
        IX_RDSEL   = 4'd4,
        IX_MODE    = 4'd5,
        IX_CARE    = 4'd6,
        IX_BITMASK = 4'd7,
        IX_PLMASK  = 4'd8
    } reg_idx_e;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_AND  = 2'd1,
        OP_OR   = 2'd2,
        OP_XOR  = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic [NPLANES-1:0] setrst;
        logic [NPLANES-1:0] sr_en;
        logic [NPLANES-1:0] cmp;
        alu_op_e            op;
        logic [2:0]         rot;
        logic [1:0]         rdsel;
        logic [1:0]         wmode;
        logic               rmode;
        logic [NPLANES-1:0] care;
        logic [BYTE_W-1:0]  bitmask;
        logic [NPLANES-1:0] plmask;
    } ctrl_t;

    // Rotate a byte right by n positions.
    function automatic logic [7:0] ror8(input logic [7:0] d, input logic [2:0] n);
        logic [15:0] t;
        t = {d, d} >> n;
        return t[7:0];
    endfunction

    // Combine a source byte with the latched byte.
    function automatic logic [7:0] alu8(input alu_op_e op, input logic [7:0] s,
                                        input logic [7:0] l);
        case (op)
            OP_AND:  return s & l;
            OP_OR:   return s | l;
            OP_XOR:  return s ^ l;
            default: return s;
        endcase
    endfunction

endpackage

// File: rtl/plane_ctrl_regs.sv
module plane_ctrl_regs
    import planar_vid_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_port,
    input  logic [7:0]  reg_wdata,
    output ctrl_t       ctrl
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q        <= '0;
            ctrl.setrst  <= '0;
            ctrl.sr_en   <= '0;
            ctrl.cmp     <= '0;
            ctrl.op      <= OP_PASS;
            ctrl.rot     <= '0;
            ctrl.rdsel   <= '0;
            ctrl.wmode   <= '0;
            ctrl.rmode   <= 1'b0;
            ctrl.care    <= '1;
            ctrl.bitmask <= '1;
            ctrl.plmask  <= '1;
        end else if (reg_wr && !reg_port) begin
            idx_q <= reg_wdata[IDX_W-1:0];
        end else if (reg_wr && reg_port) begin
            case (idx_q)
                IX_SETRST:  ctrl.setrst  <= reg_wdata[NPLANES-1:0];
                IX_SR_EN:   ctrl.sr_en   <= reg_wdata[NPLANES-1:0];
                IX_CMP:     ctrl.cmp     <= reg_wdata[NPLANES-1:0];
                IX_ROTOP: begin
                    ctrl.rot <= reg_wdata[2:0];
                    ctrl.op  <= alu_op_e'(reg_wdata[4:3]);
                end
                IX_RDSEL:   ctrl.rdsel   <= reg_wdata[1:0];
                IX_MODE: begin
                    ctrl.wmode <= reg_wdata[1:0];
                    ctrl.rmode <= reg_wdata[3];
                end
                IX_CARE:    ctrl.care    <= reg_wdata[NPLANES-1:0];
                IX_BITMASK: ctrl.bitmask <= reg_wdata;
                IX_PLMASK:  ctrl.plmask  <= reg_wdata[NPLANES-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/plane_write_unit.sv
module plane_write_unit
    import planar_vid_pkg::*;
(
    input  logic [1:0]             wmode,
    input  alu_op_e                op,
    input  logic [2:0]             rot,
    input  logic [NPLANES-1:0]     setrst,
    input  logic [NPLANES-1:0]     sr_en,
    input  logic [7:0]             bitmask,
    input  logic [7:0]             cpu_wdata,
    input  logic [NPLANES*8-1:0]   latch,
    output logic [NPLANES*8-1:0]   wr_bus
);
    logic [7:0] rot_d;
    assign rot_d = ror8(cpu_wdata, rot);

    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        logic [7:0] lat, src, msk, alu_o;
        assign lat = latch[p*8 +: 8];

        always_comb begin
            case (wmode)
                2'd0: begin
                    src = sr_en[p] ? {8{setrst[p]}} : rot_d;
                    msk = bitmask;
                end
                2'd2: begin
                    src = {8{cpu_wdata[p]}};
                    msk = bitmask;
                end
                2'd3: begin
                    src = {8{setrst[p]}};
                    msk = rot_d & bitmask;
                end
                default: begin
                    src = lat;
                    msk = 8'h00;
                end
            endcase
            alu_o = alu8(op, src, lat);
            wr_bus[p*8 +: 8] = (alu_o & msk) | (lat & ~msk);
        end
    end
endmodule

// File: rtl/plane_read_unit.sv
module plane_read_unit
    import planar_vid_pkg::*;
(
    input  logic                   rmode,
    input  logic [1:0]             rdsel,
    input  logic [NPLANES-1:0]     cmp,
    input  logic [NPLANES-1:0]     care,
    input  logic [NPLANES*8-1:0]   rd_bus,
    output logic [7:0]             rdata
);
    logic [7:0] match;

    for (genvar b = 0; b < 8; b++) begin : g_bit
        logic [NPLANES-1:0] hit;
        for (genvar p = 0; p < NPLANES; p++) begin : g_pl
            assign hit[p] = !care[p] || (rd_bus[p*8 + b] == cmp[p]);
        end
        assign match[b] = &hit;
    end

    always_comb begin
        if (rmode) rdata = match;
        else       rdata = rd_bus[rdsel*8 +: 8];
    end
endmodule

// File: rtl/planar_vid_datapath.sv
module planar_vid_datapath
    import planar_vid_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_rvalid,
    input  logic              reg_wr,
    input  logic              reg_port,
    input  logic [7:0]        reg_wdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int BUS_W = NPLANES * 8;

    ctrl_t            ctrl;
    logic             rd_req, wr_req;
    logic [BUS_W-1:0] rd_bus, wr_bus, latch_q;
    logic [7:0]       rdata_d;

    assign rd_req = cpu_req && !cpu_we;
    assign wr_req = cpu_req && cpu_we;

    plane_ctrl_regs #(.IDX_W(4)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_port(reg_port),
        .reg_wdata(reg_wdata), .ctrl(ctrl)
    );

    plane_write_unit u_wr (
        .wmode(ctrl.wmode), .op(ctrl.op), .rot(ctrl.rot),
        .setrst(ctrl.setrst), .sr_en(ctrl.sr_en), .bitmask(ctrl.bitmask),
        .cpu_wdata(cpu_wdata), .latch(latch_q), .wr_bus(wr_bus)
    );

    plane_read_unit u_rd (
        .rmode(ctrl.rmode), .rdsel(ctrl.rdsel), .cmp(ctrl.cmp),
        .care(ctrl.care), .rd_bus(rd_bus), .rdata(rdata_d)
    );

    for (genvar p = 0; p < NPLANES; p++) begin : g_mem
        logic [7:0] mem [DEPTH];
        assign rd_bus[p*8 +: 8] = mem[cpu_addr];
        always_ff @(posedge clk) begin
            if (wr_req && ctrl.plmask[p]) mem[cpu_addr] <= wr_bus[p*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q    <= '0;
            cpu_rdata  <= '0;
            cpu_rvalid <= 1'b0;
        end else begin
            cpu_rvalid <= rd_req;
            if (rd_req) begin
                latch_q   <= rd_bus;
                cpu_rdata <= rdata_d;
            end
        end
    end
endmodule

// File: rtl/planar_vid_checker.sv
module planar_vid_checker (
    input logic        clk,
    input logic        rst,
    input logic        rd_req,
    input logic        wr_req,
    input logic [1:0]  wmode,
    input logic [7:0]  bitmask,
    input logic [31:0] latch,
    input logic [31:0] rd_bus,
    input logic [31:0] wr_bus,
    input logic        rvalid
);
    assert_rvalid_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rvalid);

    assert_no_stray_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rvalid);

    assert_latch_loads_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> latch == $past(rd_bus));

    assert_latch_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(latch));

    assert_mode1_copies_latch_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wmode == 2'd1) |-> wr_bus == latch);

    assert_zero_mask_keeps_latch_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && bitmask == 8'h00) |-> wr_bus == latch);
endmodule

bind planar_vid_datapath planar_vid_checker u_chk (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
    .wmode(ctrl.wmode), .bitmask(ctrl.bitmask), .latch(latch_q),
    .rd_bus(rd_bus), .wr_bus(wr_bus), .rvalid(cpu_rvalid)
);

// File: tb/planar_vid_datapath_test.sv
module planar_vid_datapath_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_req = 0, cpu_we = 0, reg_wr = 0, reg_port = 0;
    logic [7:0] cpu_addr = 0, cpu_wdata = 0, reg_wdata = 0;
    logic [7:0] cpu_rdata;
    logic       cpu_rvalid;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench-side model state, built from the requirements.
    logic [7:0] mm [4][256];
    logic [7:0] ml [4];
    logic [3:0] m_sr = 0, m_en = 0, m_cmp = 0, m_care = 4'hF, m_pm = 4'hF;
    logic [2:0] m_rot = 0;
    logic [1:0] m_op = 0, m_sel = 0, m_wm = 0;
    logic       m_rm = 0;
    logic [7:0] m_bm = 8'hFF;

    always #5 clk = ~clk;

    planar_vid_datapath uut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rvalid(cpu_rvalid), .reg_wr(reg_wr), .reg_port(reg_port),
        .reg_wdata(reg_wdata)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic set_reg(input int idx, input logic [7:0] v);
        @(negedge clk); reg_wr = 1; reg_port = 0; reg_wdata = 8'(idx);
        @(negedge clk); reg_port = 1; reg_wdata = v;
        @(negedge clk); reg_wr = 0; reg_port = 0;
        case (idx)
            0: m_sr = v[3:0];
            1: m_en = v[3:0];
            2: m_cmp = v[3:0];
            3: begin m_rot = v[2:0]; m_op = v[4:3]; end
            4: m_sel = v[1:0];
            5: begin m_wm = v[1:0]; m_rm = v[3]; end
            6: m_care = v[3:0];
            7: m_bm = v;
            8: m_pm = v[3:0];
            default: ;
        endcase
    endtask

    function automatic logic [7:0] m_alu(input logic [7:0] s, input logic [7:0] l);
        case (m_op)
            2'd1: return s & l;
            2'd2: return s | l;
            2'd3: return s ^ l;
            default: return s;
        endcase
    endfunction

    // Read: returns the model's expected byte and compares the design's result.
    task automatic cpu_read(input logic [7:0] a, input string tag);
        logic [7:0] exp;
        for (int p = 0; p < 4; p++) ml[p] = mm[p][a];
        if (m_rm) begin
            for (int b = 0; b < 8; b++) begin
                exp[b] = 1'b1;
                for (int p = 0; p < 4; p++)
                    if (m_care[p] && (mm[p][a][b] != m_cmp[p])) exp[b] = 1'b0;
            end
        end else exp = mm[m_sel][a];
        @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_addr = a;
        @(negedge clk); cpu_req = 0;
        chk({7'd0, cpu_rvalid}, 8'd1, {tag, " rvalid R2"});
        chk(cpu_rdata, exp, tag);
    endtask

    task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] r, src, msk, o;
        r = 8'(({d, d} >> m_rot));
        for (int p = 0; p < 4; p++) begin
            case (m_wm)
                2'd0: begin src = m_en[p] ? {8{m_sr[p]}} : r; msk = m_bm; end
                2'd2: begin src = {8{d[p]}}; msk = m_bm; end
                2'd3: begin src = {8{m_sr[p]}}; msk = r & m_bm; end
                default: begin src = ml[p]; msk = 8'h00; end
            endcase
            o = (m_alu(src, ml[p]) & msk) | (ml[p] & ~msk);
            if (m_pm[p]) mm[p][a] = o;
        end
        @(negedge clk); cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk); cpu_req = 0; cpu_we = 0;
    endtask

    // Read back every plane at an address in read mode 0.
    task automatic verify(input logic [7:0] a, input string tag);
        logic [7:0] keep_mode;
        keep_mode = {4'd0, m_rm, 1'b0, m_wm};
        set_reg(5, {4'd0, 1'b0, 1'b0, m_wm});
        for (int p = 0; p < 4; p++) begin
            set_reg(4, 8'(p));
            cpu_read(a, $sformatf("%s plane%0d", tag, p));
        end
        set_reg(5, keep_mode);
    endtask

    task automatic t_reset;
        chk(cpu_rdata, 8'h00, "R1 rdata after reset");
        chk({7'd0, cpu_rvalid}, 8'h00, "R1 rvalid after reset");
        cpu_write(8'h01, 8'hA5);
        verify(8'h01, "R1 default registers");
    endtask

    task automatic t_expand;
        set_reg(5, 8'h02);
        cpu_write(8'h02, 8'h05);
        cpu_write(8'h03, 8'h0A);
        cpu_write(8'h04, 8'h0C);
        set_reg(5, 8'h00);
        verify(8'h02, "R9 R3 expand");
        verify(8'h03, "R9 expand");
        verify(8'h04, "R12 R2 expand");
    endtask

    task automatic t_rotate_ops;
        for (int op = 0; op < 4; op++) begin
            cpu_read(8'h04, "R2 latch load");
            set_reg(3, 8'((op << 3) | 3));
            cpu_write(8'h10 + 8'(op), 8'h81);
            verify(8'h10 + 8'(op), $sformatf("R4 op%0d", op));
        end
        set_reg(3, 8'h00);
    endtask

    task automatic t_setreset;
        set_reg(0, 8'h0A);
        set_reg(1, 8'h03);
        cpu_write(8'h20, 8'h3C);
        verify(8'h20, "R5 set/reset");
        set_reg(1, 8'h00);
    endtask

    task automatic t_bitmask;
        cpu_read(8'h02, "R2 latch");
        set_reg(7, 8'h0F);
        cpu_write(8'h21, 8'h66);
        set_reg(7, 8'h00);
        cpu_read(8'h03, "R2 latch");
        cpu_write(8'h22, 8'hFF);
        set_reg(7, 8'hFF);
        verify(8'h21, "R6 bitmask 0F");
        verify(8'h22, "R6 bitmask 00");
    endtask

    task automatic t_planemask;
        set_reg(8, 8'h05);
        cpu_write(8'h01, 8'h3C);
        set_reg(8, 8'h0F);
        verify(8'h01, "R7 plane mask");
    endtask

    task automatic t_latch_copy;
        cpu_read(8'h20, "R2 latch");
        set_reg(5, 8'h01);
        cpu_write(8'h30, 8'h00);
        set_reg(5, 8'h00);
        verify(8'h30, "R8 latch copy");
    endtask

    task automatic t_mode3;
        cpu_read(8'h04, "R2 latch");
        set_reg(0, 8'h06);
        set_reg(7, 8'h3C);
        set_reg(3, 8'h01);
        set_reg(5, 8'h03);
        cpu_write(8'h31, 8'hE1);
        set_reg(3, 8'h00);
        set_reg(7, 8'hFF);
        set_reg(5, 8'h00);
        verify(8'h31, "R10 mode 3");
    endtask

    task automatic t_compare;
        set_reg(5, 8'h08);
        set_reg(2, 8'h05);
        cpu_read(8'h02, "R11 compare all");
        cpu_read(8'h04, "R11 compare mismatch");
        set_reg(6, 8'h03);
        set_reg(2, 8'h01);
        cpu_read(8'h31, "R11 care mask");
        set_reg(6, 8'h00);
        cpu_read(8'h20, "R11 no care");
        set_reg(6, 8'h0F);
        set_reg(5, 8'h00);
    endtask

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_expand;
        t_rotate_ops;
        t_setreset;
        t_bitmask;
        t_planemask;
        t_latch_copy;
        t_mode3;
        t_compare;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule